// File: doc/BRIEF.md
# Low-Latency Elastic Receive Buffer

This block sits between a deserializer and the fabric. Words arrive on the recovered clock `wclk_i` with a write strobe and leave on the user clock `rclk_i` with a valid flag. The two clocks run at the same frequency. Their phase relation is unknown. Because both ends share one synchronous clock source, the buffer never inserts or deletes correction symbols. It only absorbs the phase difference between the two clocks.

The buffer holds 32 words. After reset the read pointer stays fixed while the write pointer runs ahead of it. Reading starts once the read side sees a chosen number of words in the buffer, and the pointer separation is fixed from then on. The mode is captured during reset. In normal mode the start threshold is half the depth. In low-latency mode the read side starts as soon as one word is visible, so only one or two words remain between the pointers. Which of the two it is depends on the clock phase.

Both pointers cross domains as Gray codes through flop synchronizers. Two sticky flags report a write into a full buffer and a read attempt on an empty buffer.

Top module: `elb_rx_buffer`

## Requirements
- R1: After reset, `rd_valid_o`, `ovf_o` and `unf_o` are all low.
- R2: Every word delivered with `rd_valid_o` high is the next accepted word in acceptance order. No word is repeated or skipped, and this holds across a stall of the writer.
- R3: With `lowlat_i` low during reset and continuous equal-rate writes, the distance D settles at a value from 16 to 19. D is the number of words accepted at the write port minus the number delivered, sampled in the middle of an `rclk_i` cycle.
- R4: With `lowlat_i` high during reset and continuous equal-rate writes, D settles at a value from 1 to 4.
- R5: For a fixed phase and continuous writes, D is the same on every delivered word after the first, and `rd_valid_o` stays high once it has risen.
- R6: `rd_valid_o` stays low until at least the start threshold of words has been accepted. The threshold is 16 in normal mode and 1 in low-latency mode.
- R7: `lowlat_i` is captured only while reset is asserted. Toggling it afterwards leaves D unchanged until the next reset.
- R8: When the read side finds the buffer empty after it has started, it delivers no word in that cycle and `unf_o` rises. `unf_o` stays high until reset.
- R9: A write strobe that meets a buffer holding 32 words is discarded and `ovf_o` rises. `ovf_o` stays high until reset. Neither flag rises during continuous equal-rate traffic.
- R10: Each pointer crosses domains as a Gray code that changes at most one bit per clock. At every tested phase offset the stream runs at the full word rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Recovered clock (write domain) |
| rclk_i | input | 1 | User clock (read domain), same frequency as `wclk_i` |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| lowlat_i | input | 1 | 1 selects the low-latency start threshold; captured only during reset |
| wr_en_i | input | 1 | Write strobe, `wclk_i` domain |
| wr_data_i | input | 16 | Incoming word, `wclk_i` domain |
| rd_data_o | output | 16 | Outgoing word, `rclk_i` domain |
| rd_valid_o | output | 1 | `rd_data_o` holds a new word this cycle |
| ovf_o | output | 1 | Sticky overflow flag, `wclk_i` domain |
| unf_o | output | 1 | Sticky underflow flag, `rclk_i` domain |

## Verification
The bench builds the block with its default parameters: 32 words, 16-bit data, two synchronizer stages, a normal threshold of 16 and a low-latency threshold of 1. With a threshold of 1, the one-or-two word phase effect shows up directly in D as the write clock phase is swept over four offsets. With a depth of 32, doubling the writer's rate fills the buffer within a few dozen cycles, so overflow is reached quickly. A single stall of a few cycles in low-latency mode empties the buffer, so the underflow flag and the ordering across the gap are also reached.

// File: rtl/elb_pkg.sv
`timescale 1ns/1ps
package elb_pkg;
  typedef enum logic {LAT_NORMAL = 1'b0, LAT_FAST = 1'b1} lat_mode_e;
  typedef enum logic {RD_HOLD = 1'b0, RD_RUN = 1'b1} rd_state_e;
endpackage

// File: rtl/elb_rst_sync.sv
`timescale 1ns/1ps
module elb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sh_q[STAGES-1];
endmodule

// File: rtl/elb_ptr_sync.sv
`timescale 1ns/1ps
module elb_ptr_sync #(
  parameter int unsigned W      = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] gray_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= gray_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign gray_s = stg_q[STAGES-1];

  // gray to binary: each bit is the parity of itself and all higher bits
  for (genvar b = 0; b < W; b++) begin : g_g2b
    assign bin_o[b] = ^gray_s[W-1:b];
  end
endmodule

// File: rtl/elb_wr_ctl.sv
`timescale 1ns/1ps
module elb_wr_ctl #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [PW-1:0] rptr_bin_i,
  output logic [PW-1:0] wptr_bin_o,
  output logic [PW-1:0] wptr_gray_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          wr_do_o,
  output logic          full_o,
  output logic          ovf_o
);
  logic [PW-1:0] wptr_q, wptr_nxt, gray_q, fill;
  logic          ovf_q;

  assign fill     = wptr_q - rptr_bin_i;
  assign full_o   = (fill == PW'(DEPTH));
  assign wr_do_o  = wr_en_i & ~full_o;
  assign wptr_nxt = wptr_q + PW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      gray_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (wr_do_o) begin
        wptr_q <= wptr_nxt;
        gray_q <= wptr_nxt ^ (wptr_nxt >> 1);
      end
      if (wr_en_i && full_o) ovf_q <= 1'b1;
    end
  end

  assign wptr_bin_o  = wptr_q;
  assign wptr_gray_o = gray_q;
  assign wr_addr_o   = wptr_q[AW-1:0];
  assign ovf_o       = ovf_q;
endmodule

// File: rtl/elb_rd_ctl.sv
`timescale 1ns/1ps
module elb_rd_ctl
  import elb_pkg::*;
#(
  parameter int unsigned DEPTH    = 32,
  parameter int unsigned NORM_GAP = 16,
  parameter int unsigned FAST_GAP = 1,
  localparam int unsigned AW      = $clog2(DEPTH),
  localparam int unsigned PW      = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fast_i,
  input  logic [PW-1:0] wptr_bin_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          rd_do_o,
  output logic [PW-1:0] rptr_bin_o,
  output logic [PW-1:0] rptr_gray_o,
  output logic          locked_o,
  output lat_mode_e     mode_o,
  output logic          valid_o,
  output logic          unf_o
);
  lat_mode_e     mode_q;
  rd_state_e     state_q;
  logic [PW-1:0] rptr_q, rptr_nxt, gray_q, fill, thr;
  logic          start, valid_q, unf_q;

  // mode is loaded only while the local reset is held
  always_ff @(posedge clk_i) begin
    if (!rst_ni) mode_q <= lat_mode_e'(fast_i);
  end

  assign thr      = (mode_q == LAT_FAST) ? PW'(FAST_GAP) : PW'(NORM_GAP);
  assign fill     = wptr_bin_i - rptr_q;
  assign start    = (state_q == RD_RUN) || (fill >= thr);
  assign rd_do_o  = start && (fill != '0);
  assign rptr_nxt = rptr_q + PW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RD_HOLD;
      rptr_q  <= '0;
      gray_q  <= '0;
      valid_q <= 1'b0;
      unf_q   <= 1'b0;
    end else begin
      valid_q <= rd_do_o;
      if (start) state_q <= RD_RUN;
      if (rd_do_o) begin
        rptr_q <= rptr_nxt;
        gray_q <= rptr_nxt ^ (rptr_nxt >> 1);
      end
      if (state_q == RD_RUN && fill == '0) unf_q <= 1'b1;
    end
  end

  assign rd_addr_o   = rptr_q[AW-1:0];
  assign rptr_bin_o  = rptr_q;
  assign rptr_gray_o = gray_q;
  assign locked_o    = (state_q == RD_RUN);
  assign mode_o      = mode_q;
  assign valid_o     = valid_q;
  assign unf_o       = unf_q;
endmodule

// File: rtl/elb_rx_buffer.sv
`timescale 1ns/1ps
module elb_rx_buffer
  import elb_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned DEPTH    = 32,
  parameter int unsigned SYNC_N   = 2,
  parameter int unsigned NORM_GAP = 16,
  parameter int unsigned FAST_GAP = 1,
  localparam int unsigned AW      = $clog2(DEPTH),
  localparam int unsigned PW      = AW + 1
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              lowlat_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              ovf_o,
  output logic              unf_o
);
  logic              wrst_n, rrst_n;
  logic [PW-1:0]     wptr_bin_w, wptr_gray, wptr_bin_r;
  logic [PW-1:0]     rptr_bin, rptr_gray, rptr_bin_w;
  logic [AW-1:0]     wr_addr, rd_addr;
  logic              wr_do, wr_full, rd_do, rd_locked;
  lat_mode_e         rd_mode;
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rd_data_q;

  elb_rst_sync #(.STAGES(SYNC_N)) u_wrst (
    .clk_i(wclk_i), .rst_ni(rst_ni), .rst_no(wrst_n)
  );
  elb_rst_sync #(.STAGES(SYNC_N)) u_rrst (
    .clk_i(rclk_i), .rst_ni(rst_ni), .rst_no(rrst_n)
  );

  elb_wr_ctl #(.DEPTH(DEPTH)) u_wr (
    .clk_i      (wclk_i),
    .rst_ni     (wrst_n),
    .wr_en_i    (wr_en_i),
    .rptr_bin_i (rptr_bin_w),
    .wptr_bin_o (wptr_bin_w),
    .wptr_gray_o(wptr_gray),
    .wr_addr_o  (wr_addr),
    .wr_do_o    (wr_do),
    .full_o     (wr_full),
    .ovf_o      (ovf_o)
  );

  elb_ptr_sync #(.W(PW), .STAGES(SYNC_N)) u_w2r (
    .clk_i(rclk_i), .rst_ni(rrst_n), .gray_i(wptr_gray), .bin_o(wptr_bin_r)
  );
  elb_ptr_sync #(.W(PW), .STAGES(SYNC_N)) u_r2w (
    .clk_i(wclk_i), .rst_ni(wrst_n), .gray_i(rptr_gray), .bin_o(rptr_bin_w)
  );

  elb_rd_ctl #(.DEPTH(DEPTH), .NORM_GAP(NORM_GAP), .FAST_GAP(FAST_GAP)) u_rd (
    .clk_i      (rclk_i),
    .rst_ni     (rrst_n),
    .fast_i     (lowlat_i),
    .wptr_bin_i (wptr_bin_r),
    .rd_addr_o  (rd_addr),
    .rd_do_o    (rd_do),
    .rptr_bin_o (rptr_bin),
    .rptr_gray_o(rptr_gray),
    .locked_o   (rd_locked),
    .mode_o     (rd_mode),
    .valid_o    (rd_valid_o),
    .unf_o      (unf_o)
  );

  always_ff @(posedge wclk_i) begin
    if (wr_do) mem_q[wr_addr] <= wr_data_i;
  end

  always_ff @(posedge rclk_i or negedge rrst_n) begin
    if (!rrst_n)    rd_data_q <= '0;
    else if (rd_do) rd_data_q <= mem_q[rd_addr];
  end

  assign rd_data_o = rd_data_q;
endmodule

// File: rtl/elb_rx_buffer_chk.sv
`timescale 1ns/1ps
module elb_rx_buffer_chk #(
  parameter int unsigned PW = 6
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          wrst_n,
  input logic          rrst_n,
  input logic          wr_en_i,
  input logic          wr_full,
  input logic [PW-1:0] wptr_bin_w,
  input logic [PW-1:0] wptr_gray,
  input logic [PW-1:0] rptr_bin,
  input logic [PW-1:0] rptr_gray,
  input logic          rd_locked,
  input logic          rd_mode,
  input logic          rd_valid_o,
  input logic          ovf_o,
  input logic          unf_o
);
  AST_NO_VALID_UNLOCKED: assert property (@(posedge rclk_i) disable iff (!rrst_n)
    !rd_locked |-> !rd_valid_o);                                        // R6
  AST_RPTR_SINGLE_STEP: assert property (@(posedge rclk_i) disable iff (!rrst_n)
    (rptr_bin != $past(rptr_bin)) |-> (rptr_bin == $past(rptr_bin) + PW'(1))); // R2
  AST_VALID_MEANS_READ: assert property (@(posedge rclk_i) disable iff (!rrst_n)
    rd_valid_o |-> (rptr_bin != $past(rptr_bin)));                      // R2
  AST_WGRAY_ONE_BIT: assert property (@(posedge wclk_i) disable iff (!wrst_n)
    $countones(wptr_gray ^ $past(wptr_gray)) <= 1);                     // R10
  AST_RGRAY_ONE_BIT: assert property (@(posedge rclk_i) disable iff (!rrst_n)
    $countones(rptr_gray ^ $past(rptr_gray)) <= 1);                     // R10
  AST_FULL_DROPS_WRITE: assert property (@(posedge wclk_i) disable iff (!wrst_n)
    (wr_full && wr_en_i) |=> $stable(wptr_bin_w));                      // R9
  AST_OVF_STICKY: assert property (@(posedge wclk_i) disable iff (!wrst_n)
    ovf_o |=> ovf_o);                                                   // R9
  AST_UNF_STICKY: assert property (@(posedge rclk_i) disable iff (!rrst_n)
    unf_o |=> unf_o);                                                   // R8
  AST_MODE_FROZEN: assert property (@(posedge rclk_i) disable iff (!rrst_n)
    rrst_n |=> $stable(rd_mode));                                       // R7
endmodule

bind elb_rx_buffer elb_rx_buffer_chk #(.PW(PW)) u_chk (
  .wclk_i    (wclk_i),
  .rclk_i    (rclk_i),
  .wrst_n    (wrst_n),
  .rrst_n    (rrst_n),
  .wr_en_i   (wr_en_i),
  .wr_full   (wr_full),
  .wptr_bin_w(wptr_bin_w),
  .wptr_gray (wptr_gray),
  .rptr_bin  (rptr_bin),
  .rptr_gray (rptr_gray),
  .rd_locked (rd_locked),
  .rd_mode   (rd_mode),
  .rd_valid_o(rd_valid_o),
  .ovf_o     (ovf_o),
  .unf_o     (unf_o)
);

// File: tb/sim_elb_rx_buffer.sv
`timescale 1ns/1ps
module sim_elb_rx_buffer;
  logic        wclk = 1'b0, rclk = 1'b0, rst_ni = 1'b0, lowlat_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] rd_data_o;
  logic        rd_valid_o, ovf_o, unf_o;

  int          total = 0, bad = 0;
  bit          done = 0;
  bit          wr_on = 0, w_run = 0;
  realtime     w_half = 2.5, w_phase = 0.6;
  int          acc = 0;
  logic [15:0] wseq = 16'h1200;

  elb_rx_buffer u0 (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_ni), .lowlat_i(lowlat_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  always #2.5 rclk = ~rclk;  // 200 MHz user clock

  // recovered clock: restartable, phase set relative to rclk
  initial forever begin
    wait (w_run);
    @(posedge rclk);
    #(w_phase);
    while (w_run) begin
      wclk = 1'b1; #(w_half);
      wclk = 1'b0; #(w_half);
    end
  end

  initial forever begin
    @(negedge wclk);
    wr_en_i   = wr_on;
    wr_data_i = wseq;
  end

  initial forever begin
    @(posedge wclk);
    if (wr_en_i) begin
      acc++;
      wseq++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit fast, input realtime half, input realtime ph);
    wr_on  = 0;
    rst_ni = 1'b0;
    w_run  = 0;
    #20;
    w_half   = half;
    w_phase  = ph;
    w_run    = 1;
    lowlat_i = fast;
    repeat (8) @(negedge rclk);
    rst_ni = 1'b1;
    repeat (6) @(negedge rclk);
    chk(!rd_valid_o && !ovf_o && !unf_o, "R1 reset state",
        {rd_valid_o, ovf_o, unf_o}, 0);
    wseq = wseq + 16'h0311;
    acc  = 0;
  endtask

  task automatic run_stream(input bit fast, input realtime ph, input int cycles,
                            input int flip_at);
    int d0 = -1, deliv = 0, nval = 0, ord_err = 0, gap_err = 0, d_err = 0;
    int first_acc = -1, d_last = 0;
    bit started = 0;
    logic [15:0] exp;
    int thr = fast ? 1 : 16;
    do_reset(fast, 2.5, ph);
    exp   = wseq;
    wr_on = 1;
    for (int i = 0; i < cycles; i++) begin
      @(negedge rclk);
      if (i == flip_at) lowlat_i = ~lowlat_i;
      if (rd_valid_o) begin
        if (!started) begin started = 1; first_acc = acc; end
        deliv++; nval++;
        if (rd_data_o !== exp) ord_err++;
        exp++;
        d_last = acc - deliv;
        if (d0 < 0) d0 = d_last;
        else if (d_last != d0) d_err++;
      end else if (started) gap_err++;
    end
    wr_on = 0;
    chk(ord_err == 0, "R2 order", ord_err, 0);
    chk(first_acc >= thr, "R6 start threshold", first_acc, thr);
    chk(d_err == 0 && gap_err == 0, "R5 constant distance", d_err + gap_err, 0);
    if (fast) chk(d0 >= 1 && d0 <= 4, "R4 low-latency distance", d0, 2);
    else      chk(d0 >= 16 && d0 <= 19, "R3 normal distance", d0, 17);
    if (flip_at >= 0)
      chk(d_last == d0 && d_err == 0, "R7 mode change ignored", d_last, d0);
    chk(nval >= cycles - 30, "R10 full rate at phase", nval, cycles - 30);
    chk(!ovf_o && !unf_o, "R9 no flags in steady traffic", {ovf_o, unf_o}, 0);
  endtask

  task automatic t_underflow();
    int ord_err = 0, holes = 0;
    bit started = 0;
    logic [15:0] exp;
    do_reset(1'b1, 2.5, 1.7);
    exp   = wseq;
    wr_on = 1;
    for (int i = 0; i < 260; i++) begin
      @(negedge rclk);
      if (i == 99)  chk(!unf_o, "R8 no underflow before stall", unf_o, 0);
      if (i == 100) wr_on = 0;
      if (i == 110) wr_on = 1;
      if (rd_valid_o) begin
        started = 1;
        if (rd_data_o !== exp) ord_err++;
        exp++;
      end else if (started) holes++;
    end
    chk(ord_err == 0, "R2 order across stall", ord_err, 0);
    chk(holes > 0, "R8 no word while empty", holes, 1);
    chk(unf_o, "R8 underflow sticky after resume", unf_o, 1);
    wr_on = 0;
  endtask

  task automatic t_overflow();
    do_reset(1'b0, 1.25, 0.6);
    wr_on = 1;
    repeat (200) @(negedge rclk);
    chk(ovf_o, "R9 overflow raised", ovf_o, 1);
    wr_on = 0;
    repeat (80) @(negedge rclk);
    chk(ovf_o, "R9 overflow sticky", ovf_o, 1);
  endtask

  initial begin
    realtime phases[4] = '{0.6, 1.7, 3.1, 4.3};
    foreach (phases[k]) begin
      run_stream(1'b0, phases[k], 160, -1);
      run_stream(1'b1, phases[k], 160, -1);
    end
    run_stream(1'b1, 3.1, 200, 60);
    run_stream(1'b0, 1.7, 200, 80);
    t_underflow();
    t_overflow();
    do_reset(1'b0, 2.5, 0.6);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule